// File: doc/BRIEF.md
# I2C Master Register Front-End

This block is the software-facing half of an I2C master. A processor reaches five byte-wide registers through a simple request/acknowledge port: own address, clock divider, control, status and data. The block turns those register accesses into bus transactions. It hands each transaction to a transaction-level bus agent through a request/done handshake. The agent reports an acknowledge result, and for a receive it also returns a data byte. Bit-level SCL/SDA timing, slave operation and arbitration detection belong to other blocks. The divider value is only stored.

A transfer is driven entirely by side effects of register accesses:
- The first data write after the address state is idle becomes the address byte.
- Later data writes send payload bytes.
- A data read returns the byte fetched earlier and fetches the next one.
- Control writes can end a transfer, either by leaving master mode or by requesting a repeated start.
- Clearing the enable bit performs a soft reset that keeps the own address.

While a bus operation is outstanding, the register port holds ready low. The access is acknowledged only after the agent answers.

Top module: `i2c_master_regfe`

## Requirements
- R1: After hardware reset every register reads 0, `irq` is low and `reg_rdy` is high. If a target address was active when reset was applied, the block issues one end operation (kind 3) after reset is released.
- R2: Register offsets are:
  - own address at 0x00, storing bits 7:1
  - divider at 0x04, storing bits 5:0
  - control at 0x08, storing bits 7:2
  - status at 0x0C
  - data at 0x10

  Only the low 8 bits of a write are used. Any other offset reads 0, and a write to it changes nothing.
- R3: A control write with bit 7 (enable) clear, made while enabled, is a soft reset. It issues an end operation if an address is active. It returns divider, control, status and the read buffer to 0, and it keeps the own address.
- R4: A normal control write copies bit 5 (master) into status bit 5 (busy). If master is written 0 while an address is active, an end operation is issued and the address state becomes idle.
- R5: If a normal control write sets bit 2 (repeated start) while an address is active, an end operation is issued, the address state becomes idle and bit 2 reads back 0. When no address is active, bit 2 keeps the written value.
- R6: A data write while disabled issues no operation. With master mode set and the address state idle, a data write issues a start operation (kind 0) carrying the byte: bits 7:1 are the target and bit 0 is the direction.
  - A NACK sets status bit 0 (RXAK) and leaves the address state idle.
  - An ACK makes the address active, clears RXAK and raises the interrupt flag.
- R7: With an address active, a data write issues a send operation (kind 1).
  - An ACK clears RXAK and raises the interrupt flag.
  - A NACK sets RXAK, issues an end operation and returns the address state to idle.
- R8: A data read returns the read buffer.
  - In master mode with an address active and control bit 4 (transmit) clear, the read issues a receive operation (kind 2); the received byte becomes the buffer and the interrupt flag is raised.
  - In master mode otherwise, the buffer becomes 0xFF.
- R9: The interrupt flag (status bit 1) is set only while enabled. `irq` is high only when the flag and control bit 6 (irq enable) are both set.
- R10: Status writes only clear bits. Writing 0 to bit 1 clears the interrupt flag and drops `irq`. Writing 0 to bit 4 clears arbitration-lost. Writing 1 changes nothing.
- R11: While an operation is outstanding, `reg_rdy` is low, `op_req` stays high and `op_kind`/`op_byte` are stable until `op_done`. An accepted access gets one `reg_ack` pulse carrying the read value, once its operations have completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data (low 8 bits used) |
| reg_rdy | output | 1 | Access accepted on a clock edge where this and `reg_sel` are high |
| reg_ack | output | 1 | One-cycle completion pulse |
| reg_rdata | output | DATA_W | Read value, valid with `reg_ack` |
| irq | output | 1 | Interrupt line |
| op_req | output | 1 | Bus operation request, held until `op_done` |
| op_kind | output | 2 | 0 start, 1 send, 2 receive, 3 end |
| op_byte | output | 8 | Address byte for start, data for send |
| op_done | input | 1 | Operation completed |
| op_nack | input | 1 | Target did not acknowledge |
| op_rdata | input | 8 | Byte returned by a receive |

## Verification
The following properties are checked on every cycle:
- the request hold-and-stability handshake
- exclusion of register acceptance while a request is open
- the busy flag tracking the written master bit
- the repeated-start bit clearing itself when a transfer is active
- the own address surviving a soft reset
- the interrupt flag rising only while enabled

Other behaviour can only be shown by the bench's scenarios: the order and content of operations, the prefetch offset of data reads, the NACK-then-end sequence, and the end operation issued after a hardware reset. A scoreboard of expected operations is compared against what the bus agent model sees.

// File: rtl/i2cfe_pkg.sv
// Package: shared types and field positions for the I2C master register front-end.
// Assumes: byte-wide registers, bit positions fixed by the software interface.
package i2cfe_pkg;

    localparam int NREG = 5;

    // Register indices (offset = index * stride)
    localparam int RG_OWN = 0;
    localparam int RG_DIV = 1;
    localparam int RG_CTL = 2;
    localparam int RG_STA = 3;
    localparam int RG_DAT = 4;

    // Control bits
    localparam int CTL_EN = 7;
    localparam int CTL_IE = 6;
    localparam int CTL_MS = 5;
    localparam int CTL_TX = 4;
    localparam int CTL_RS = 2;

    // Status bits
    localparam int STA_BB = 5;
    localparam int STA_AL = 4;
    localparam int STA_IF = 1;
    localparam int STA_RX = 0;

    localparam logic [7:0] OWN_MASK = 8'hFE;
    localparam logic [7:0] DIV_MASK = 8'h3F;
    localparam logic [7:0] CTL_MASK = 8'hFC;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_END   = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_XFER   = 3'd1,
        ST_TAIL   = 3'd2,
        ST_HWREQ  = 3'd3,
        ST_HWWAIT = 3'd4
    } fsm_e;

endpackage

// File: rtl/i2cfe_decode.sv
// Module: one-hot register select from a byte offset.
// Assumes: registers sit at index * STRIDE; any other offset selects nothing.
module i2cfe_decode #(
    parameter int ADDR_W = 5,
    parameter int STRIDE = 4,
    parameter int NSEL   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEL-1:0]   sel
);

    // One comparator per register offset
    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        localparam int unsigned OFF = i * STRIDE;
        assign sel[i] = (addr == ADDR_W'(OFF));
    end

endmodule

// File: rtl/i2cfe_busport.sv
// Module: request/done handshake toward the transaction-level bus agent.
// Assumes: go is only raised when no request is open, or on the edge that
// closes the current one (back-to-back chaining).
module i2cfe_busport
    import i2cfe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  bus_op_e go_kind,
    input  logic [7:0] go_byte,
    input  logic    op_done,
    output logic    op_req,
    output bus_op_e op_kind,
    output logic [7:0] op_byte,
    output logic    done
);

    logic    req_q;
    bus_op_e kind_q;
    logic [7:0] byte_q;

    // Open a request on go, close it when the agent reports done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            kind_q <= OP_END;
            byte_q <= 8'h00;
        end else if (go) begin
            req_q  <= 1'b1;
            kind_q <= go_kind;
            byte_q <= go_byte;
        end else if (op_done) begin
            req_q  <= 1'b0;
        end
    end

    assign op_req  = req_q;
    assign op_kind = kind_q;
    assign op_byte = byte_q;
    assign done    = req_q & op_done;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !op_done) |=> (req_q && $stable(kind_q) && $stable(byte_q)));

    assert_go_when_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (!req_q || op_done));

endmodule

// File: rtl/i2c_master_regfe.sv
// Module: register front-end of an I2C master. Register accesses drive bus
// transactions (start / send / receive / end) through a request/done port.
// Assumes: one register access in flight; the agent always answers op_req.
module i2c_master_regfe
    import i2cfe_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 16,
    parameter int REG_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rdy,
    output logic              reg_ack,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              op_req,
    output logic [1:0]        op_kind,
    output logic [7:0]        op_byte,
    input  logic              op_done,
    input  logic              op_nack,
    input  logic [7:0]        op_rdata
);

    logic [7:0] own_q, div_q, ctl_q, sta_q, rbuf_q;
    logic       active_q;
    fsm_e       st_q;
    bus_op_e    pend_q;
    logic       ack_q;
    logic [DATA_W-1:0] rdata_q;

    logic [NREG-1:0] sel;
    logic       accept, soft_rst, need_end, bp_done;
    logic [7:0] wr_b, rd_val;
    logic       go;
    bus_op_e    go_kind;
    logic [7:0] go_byte;
    bus_op_e    bp_kind;
    logic       unused_wdata_hi;

    assign wr_b            = reg_wdata[7:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:8];
    assign reg_rdy         = (st_q == ST_IDLE);
    assign accept          = reg_sel & reg_rdy;
    assign soft_rst        = ctl_q[CTL_EN] & ~wr_b[CTL_EN];
    assign need_end        = active_q & (~wr_b[CTL_MS] | wr_b[CTL_RS]);

    i2cfe_decode #(.ADDR_W(ADDR_W), .STRIDE(REG_STRIDE), .NSEL(NREG)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    // Read value of the addressed register; unmapped offsets give 0
    always_comb begin
        rd_val = 8'h00;
        if (sel[RG_OWN]) rd_val = own_q;
        if (sel[RG_DIV]) rd_val = div_q;
        if (sel[RG_CTL]) rd_val = ctl_q;
        if (sel[RG_STA]) rd_val = sta_q;
        if (sel[RG_DAT]) rd_val = rbuf_q;
    end

    // Decide whether this cycle launches a bus operation, and which
    always_comb begin
        go      = 1'b0;
        go_kind = OP_END;
        go_byte = 8'h00;
        if (st_q == ST_HWREQ) begin
            go = 1'b1;
        end else if (st_q == ST_XFER && bp_done && pend_q == OP_SEND && op_nack) begin
            go = 1'b1;
        end else if (accept && reg_wr && sel[RG_DAT]) begin
            if (ctl_q[CTL_EN] && ctl_q[CTL_MS]) begin
                go      = 1'b1;
                go_kind = active_q ? OP_SEND : OP_START;
                go_byte = wr_b;
            end
        end else if (accept && !reg_wr && sel[RG_DAT]) begin
            if (ctl_q[CTL_MS] && active_q && !ctl_q[CTL_TX]) begin
                go      = 1'b1;
                go_kind = OP_RECV;
            end
        end else if (accept && reg_wr && sel[RG_CTL]) begin
            go = soft_rst ? active_q : need_end;
        end
    end

    i2cfe_busport u_bp (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .go_kind (go_kind),
        .go_byte (go_byte),
        .op_done (op_done),
        .op_req  (op_req),
        .op_kind (bp_kind),
        .op_byte (op_byte),
        .done    (bp_done)
    );

    assign op_kind   = bp_kind;
    assign reg_ack   = ack_q;
    assign reg_rdata = rdata_q;
    assign irq       = sta_q[STA_IF] & ctl_q[CTL_IE];

    // Register state, address state and access sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q    <= 8'h00;
            div_q    <= 8'h00;
            ctl_q    <= 8'h00;
            sta_q    <= 8'h00;
            rbuf_q   <= 8'h00;
            active_q <= 1'b0;
            ack_q    <= 1'b0;
            rdata_q  <= '0;
            pend_q   <= OP_END;
            st_q     <= (active_q || st_q == ST_HWREQ || st_q == ST_HWWAIT)
                        ? ST_HWREQ : ST_IDLE;
        end else begin
            ack_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        rdata_q <= DATA_W'(rd_val);
                        if (go) begin
                            pend_q <= go_kind;
                            st_q   <= ST_XFER;
                        end else begin
                            ack_q <= 1'b1;
                        end
                        if (reg_wr) begin
                            if (sel[RG_OWN]) own_q <= wr_b & OWN_MASK;
                            if (sel[RG_DIV]) div_q <= wr_b & DIV_MASK;
                            if (sel[RG_CTL]) begin
                                if (soft_rst) begin
                                    div_q    <= 8'h00;
                                    ctl_q    <= 8'h00;
                                    sta_q    <= 8'h00;
                                    rbuf_q   <= 8'h00;
                                    active_q <= 1'b0;
                                end else begin
                                    ctl_q <= (wr_b & CTL_MASK) &
                                             ~((active_q && wr_b[CTL_RS]) ? (8'h01 << CTL_RS) : 8'h00);
                                    sta_q[STA_BB] <= wr_b[CTL_MS];
                                    if (need_end) active_q <= 1'b0;
                                end
                            end
                            if (sel[RG_STA]) begin
                                if (!wr_b[STA_IF]) sta_q[STA_IF] <= 1'b0;
                                if (!wr_b[STA_AL]) sta_q[STA_AL] <= 1'b0;
                            end
                        end else if (sel[RG_DAT] && ctl_q[CTL_MS] &&
                                     !(active_q && !ctl_q[CTL_TX])) begin
                            rbuf_q <= 8'hFF;
                        end
                    end
                end
                ST_XFER: begin
                    if (bp_done) begin
                        st_q  <= ST_IDLE;
                        ack_q <= 1'b1;
                        case (pend_q)
                            OP_START: begin
                                if (op_nack) begin
                                    sta_q[STA_RX] <= 1'b1;
                                end else begin
                                    active_q      <= 1'b1;
                                    sta_q[STA_RX] <= 1'b0;
                                    if (ctl_q[CTL_EN]) sta_q[STA_IF] <= 1'b1;
                                end
                            end
                            OP_SEND: begin
                                if (op_nack) begin
                                    sta_q[STA_RX] <= 1'b1;
                                    active_q      <= 1'b0;
                                    st_q          <= ST_TAIL;
                                    ack_q         <= 1'b0;
                                end else begin
                                    sta_q[STA_RX] <= 1'b0;
                                    if (ctl_q[CTL_EN]) sta_q[STA_IF] <= 1'b1;
                                end
                            end
                            OP_RECV: begin
                                rbuf_q <= op_rdata;
                                if (ctl_q[CTL_EN]) sta_q[STA_IF] <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_TAIL: begin
                    if (bp_done) begin
                        st_q  <= ST_IDLE;
                        ack_q <= 1'b1;
                    end
                end
                ST_HWREQ:  st_q <= ST_HWWAIT;
                ST_HWWAIT: if (bp_done) st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    assert_rdy_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |-> !reg_rdy);

    assert_busy_tracks_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reg_wr && sel[RG_CTL] && !soft_rst) |=> (sta_q[STA_BB] == ctl_q[CTL_MS]));

    assert_rsta_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reg_wr && sel[RG_CTL] && !soft_rst && active_q && wr_b[CTL_RS])
        |=> (!ctl_q[CTL_RS] && !active_q));

    assert_soft_keeps_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reg_wr && sel[RG_CTL] && soft_rst)
        |=> (own_q == $past(own_q) && ctl_q == 8'h00 && sta_q == 8'h00));

    assert_flag_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sta_q[STA_IF]) |-> ctl_q[CTL_EN]);

endmodule

// File: tb/sim_i2c_master_regfe.sv
`timescale 1ns/1ps
module sim_i2c_master_regfe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rdy, reg_ack, irq, op_req;
    logic [15:0] reg_rdata;
    logic [1:0]  op_kind;
    logic [7:0]  op_byte;
    logic        op_done = 1'b0, op_nack = 1'b0;
    logic [7:0]  op_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0] kind;
        logic [7:0] b;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    logic [7:0] rcv_ctr = 8'hA0;

    always #2.5 clk = ~clk;

    i2c_master_regfe u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdy(reg_rdy),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata), .irq(irq),
        .op_req(op_req), .op_kind(op_kind), .op_byte(op_byte),
        .op_done(op_done), .op_nack(op_nack), .op_rdata(op_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_op(input logic [1:0] k, input logic [7:0] b, input string tag);
        exp_t e;
        e.kind = k; e.b = b; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic acc(input bit w, input logic [4:0] a, input logic [15:0] d,
                       output logic [15:0] r);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = w; reg_addr = a; reg_wdata = d;
        while (!reg_rdy) @(negedge clk);
        @(negedge clk);
        reg_sel = 1'b0;
        while (!reg_ack) @(negedge clk);
        r = reg_rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        logic [15:0] r;
        acc(1'b1, a, d, r);
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] r;
        acc(1'b0, a, 16'h0, r);
        chk(tag, r, exp);
    endtask

    // Bus agent model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && op_req) begin
                logic [1:0] k;
                logic [7:0] b;
                k = op_kind; b = op_byte;
                chk("R11 ready low during op", {15'd0, reg_rdy}, 16'd0);
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected op kind", {14'd0, k}, 16'hFFFF);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " op kind"}, {14'd0, k}, {14'd0, e.kind});
                    if (e.kind == 2'd0 || e.kind == 2'd1)
                        chk({e.tag, " op byte"}, {8'd0, b}, {8'd0, e.b});
                end
                repeat (3) @(negedge clk);
                chk("R11 kind stable", {14'd0, op_kind}, {14'd0, k});
                op_nack  = (k == 2'd0) ? (b[7:1] != 7'h50) :
                           (k == 2'd1) ? (b == 8'hEE) : 1'b0;
                op_rdata = (k == 2'd2) ? rcv_ctr : 8'h00;
                if (k == 2'd2) rcv_ctr = rcv_ctr + 8'd1;
                op_done = 1'b1;
                @(negedge clk);
                op_done = 1'b0;
                op_nack = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {15'd0, reg_rdy}, 16'd1);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        rd_chk(5'h00, 16'h0, "R1 own");
        rd_chk(5'h04, 16'h0, "R1 div");
        rd_chk(5'h08, 16'h0, "R1 ctl");
        rd_chk(5'h0C, 16'h0, "R1 sta");
        rd_chk(5'h10, 16'h0, "R1 dat");

        // R2 masks, low byte only, unmapped offset
        wr(5'h00, 16'hABFF);  rd_chk(5'h00, 16'h00FE, "R2 own mask");
        wr(5'h04, 16'h12FF);  rd_chk(5'h04, 16'h003F, "R2 div mask");
        wr(5'h14, 16'h00FF);
        rd_chk(5'h14, 16'h0000, "R2 unmapped read");
        rd_chk(5'h08, 16'h0000, "R2 unmapped write no effect");

        // R6 data write while disabled: no op (monitor flags any)
        wr(5'h10, 16'h00A0);
        rd_chk(5'h0C, 16'h0000, "R6 disabled write status");

        // R4 master set -> busy
        wr(5'h08, 16'h00F0);
        rd_chk(5'h0C, 16'h0020, "R4 busy set");

        // R6 start ack, R9 irq
        expect_op(2'd0, 8'hA0, "R6 start");
        wr(5'h10, 16'h00A0);
        rd_chk(5'h0C, 16'h0022, "R6 start ack status");
        chk("R9 irq with enable", {15'd0, irq}, 16'd1);

        // R10 write-zero-to-clear
        wr(5'h0C, 16'h00FF);  rd_chk(5'h0C, 16'h0022, "R10 write ones no effect");
        wr(5'h0C, 16'h0000);  rd_chk(5'h0C, 16'h0020, "R10 clear flag");
        chk("R10 irq dropped", {15'd0, irq}, 16'd0);

        // R7 send ack then send nack -> end
        expect_op(2'd1, 8'h33, "R7 send");
        wr(5'h10, 16'h0033);
        rd_chk(5'h0C, 16'h0022, "R7 send ack status");
        wr(5'h0C, 16'h0000);
        expect_op(2'd1, 8'hEE, "R7 send nack");
        expect_op(2'd3, 8'h00, "R7 end after nack");
        wr(5'h10, 16'h00EE);
        rd_chk(5'h0C, 16'h0021, "R7 nack status");

        // R6 start nack stays idle: next write is a start again
        expect_op(2'd0, 8'h62, "R6 start nack");
        wr(5'h10, 16'h0062);
        rd_chk(5'h0C, 16'h0021, "R6 nack rxak");
        expect_op(2'd0, 8'hA1, "R6 start after nack");
        wr(5'h10, 16'h00A1);
        rd_chk(5'h0C, 16'h0022, "R6 read start ack");
        wr(5'h0C, 16'h0000);

        // R8 receive with prefetch (transmit clear)
        wr(5'h08, 16'h00E0);
        expect_op(2'd2, 8'h00, "R8 recv1");
        rd_chk(5'h10, 16'h0000, "R8 first read old buffer");
        rd_chk(5'h0C, 16'h0022, "R8 recv raises flag");
        expect_op(2'd2, 8'h00, "R8 recv2");
        rd_chk(5'h10, 16'h00A0, "R8 second read prefetched");

        // R5 repeated start with active address
        expect_op(2'd3, 8'h00, "R5 end on restart");
        wr(5'h08, 16'h00E4);
        rd_chk(5'h08, 16'h00E0, "R5 restart bit self-clears");

        // R8 idle read in master: returns buffer, loads 0xFF, no op
        rd_chk(5'h10, 16'h00A1, "R8 idle read buffer");
        rd_chk(5'h10, 16'h00FF, "R8 buffer set to FF");

        // R9 gating by irq enable
        wr(5'h0C, 16'h0000);
        wr(5'h08, 16'h00A0);
        expect_op(2'd0, 8'hA0, "R9 start");
        wr(5'h10, 16'h00A0);
        rd_chk(5'h0C, 16'h0022, "R9 flag set");
        chk("R9 irq masked", {15'd0, irq}, 16'd0);
        wr(5'h08, 16'h00E0);
        chk("R9 irq unmasked", {15'd0, irq}, 16'd1);

        // R3 soft reset with active address
        expect_op(2'd3, 8'h00, "R3 end on soft reset");
        wr(5'h08, 16'h0000);
        rd_chk(5'h08, 16'h0000, "R3 ctl cleared");
        rd_chk(5'h0C, 16'h0000, "R3 sta cleared");
        rd_chk(5'h04, 16'h0000, "R3 div cleared");
        rd_chk(5'h00, 16'h00FE, "R3 own kept");
        chk("R3 irq low", {15'd0, irq}, 16'd0);

        // R4 master clear ends transfer
        wr(5'h08, 16'h0080);
        wr(5'h08, 16'h00A0);
        expect_op(2'd0, 8'hA0, "R4 start");
        wr(5'h10, 16'h00A0);
        expect_op(2'd3, 8'h00, "R4 end on master clear");
        wr(5'h08, 16'h0080);
        rd_chk(5'h0C, 16'h0002, "R4 busy cleared");

        // R5 restart bit kept when idle
        wr(5'h08, 16'h0084);
        rd_chk(5'h08, 16'h0084, "R5 restart kept when idle");

        // R1 hardware reset with active address issues end
        wr(5'h08, 16'h00A0);
        expect_op(2'd0, 8'hA0, "R1 start before reset");
        wr(5'h10, 16'h00A0);
        expect_op(2'd3, 8'h00, "R1 end after hw reset");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        rd_chk(5'h00, 16'h0000, "R1 own after hw reset");
        rd_chk(5'h08, 16'h0000, "R1 ctl after hw reset");
        chk("R1 all ops seen", 16'(exp_q.size()), 16'd0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule